// File: doc/BRIEF.md
# Universal Bus Transceiver Data Path

The block moves an 18-bit word between an A bus and a B bus in both directions. Each direction owns a storage path that combines a level-sensitive latch and an edge-triggered register. A high latch enable makes the path transparent, so the destination follows the source. With the latch enable low, the path presents a stored word. That word changes only when the direction's own capture clock rises, and it holds while that clock sits at either static level. Each direction also has an active-low output enable. It decides whether the destination bus is driven or released.

All control inputs are sampled by the system clock `clk`. A rising capture clock is recognised at the first system edge where the capture clock reads high after having read low, and the word present at that edge is loaded. The transparent view is combinational from the source bus. The word is split into lanes that share one set of controls, so the path serves as one 18-bit transceiver or as two 9-bit transceivers. Buses are modelled with separate input, output and drive-enable ports, and the drive enable is the tri-state control for a pad ring.

Top module: `ubt_core`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle. While `ba_le` is 1, `a_out` equals `b_in`.
- R2: While `ab_le` is 0 and `ab_clk` is held at a constant 0 or 1, `b_out` keeps the stored word. A falling `ab_clk` does not change it.
- R3: While `ab_le` is 0, the first `clk` edge that samples `ab_clk` at 1 after it sampled 0 loads `a_in` into the stored word. `b_out` shows the new word from that edge on.
- R4: When `ab_le` goes from 1 to 0, the stored word equals `a_in` as sampled at the last `clk` edge with `ab_le` at 1. A value that arrives together with the fall is not taken.
- R5: `b_drive` is 1 exactly when `ab_oe_n` is 0 and `rst_n` is 1. `a_drive` follows `ba_oe_n` the same way.
- R6: The B-to-A path obeys R1 to R4 through `ba_le`, `ba_clk` and `b_in`, and drives `a_out`.
- R7: Activity on one direction's controls or source bus never alters the word stored in the other direction.
- R8: While `rst_n` is 0, both stored words are 0 and both drive enables are 0. The rise detector starts as if it had seen 1, so a capture clock held at 1 through reset captures nothing.
- R9: With both output enables at 0, both `a_drive` and `b_drive` are 1, and neither direction has priority.
- R10: The word is built of `LANES` lanes of `WIDTH/LANES` bits. With the defaults, bits 17:9 and bits 8:0 each carry their own data under the shared controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the controls |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Data read from the A bus |
| a_out | output | 18 | Data to drive onto the A bus |
| a_drive | output | 1 | A bus drive enable (1 = drive) |
| b_in | input | 18 | Data read from the B bus |
| b_out | output | 18 | Data to drive onto the B bus |
| b_drive | output | 1 | B bus drive enable (1 = drive) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B capture clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A capture clock |

## Verification
A vector sequence steps the A-to-B path through transparent mode, static-high and static-low capture clocks, rising and falling clock edges, and a latch-enable fall. It changes the data on cycles where a correct design must ignore it, which separates a true rising edge from any level or falling-edge capture. Directed cases change the source data in the same cycle as the latch-enable fall, hold the capture clock high through reset, and interleave both directions to show that the stored words stay independent. Others enable both drivers at once and report the contention, and load distinct lane patterns to show the halves carry their own data.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // What a storage path does at the next system clock edge
  typedef enum logic [0:0] {
    ST_HOLD = 1'b0,
    ST_LOAD = 1'b1
  } store_op_e;

  // Which word a path presents at its destination
  typedef enum logic [0:0] {
    VIEW_HELD = 1'b0,
    VIEW_LIVE = 1'b1
  } view_e;

  // Transparent mode keeps loading, so the held word is always the
  // last sample taken before the enable fell; otherwise only a clock
  // rise loads.
  function automatic store_op_e store_op(input logic le, input logic rise);
    return (le || rise) ? ST_LOAD : ST_HOLD;
  endfunction

  function automatic view_e view_sel(input logic le);
    return le ? VIEW_LIVE : VIEW_HELD;
  endfunction

  function automatic logic drive_on(input logic rst_n, input logic oe_n);
    return rst_n && !oe_n;
  endfunction

endpackage

// File: rtl/ubt_rise_detect.sv
module ubt_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic level_q;

  // Starts at 1: a level held high through reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level;
  end

  assign rise = level && !level_q;

endmodule

// File: rtl/ubt_lane_store.sv
module ubt_lane_store
  import ubt_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  store_op_e         op,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (op == ST_LOAD)  q <= d;
  end

endmodule

// File: rtl/ubt_direction.sv
module ubt_direction
  import ubt_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src,
  input  logic             oe_n,
  input  logic             le,
  input  logic             cap_clk,
  output logic [WIDTH-1:0] dst,
  output logic             drive,
  output logic [WIDTH-1:0] held,
  output logic             rise
);

  localparam int LANE_W = WIDTH / LANES;

  store_op_e op;
  view_e     view;

  ubt_rise_detect u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cap_clk),
    .rise  (rise)
  );

  assign op   = store_op(le, rise);
  assign view = view_sel(le);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ubt_lane_store #(.LANE_W(LANE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .d     (src[g*LANE_W +: LANE_W]),
      .q     (held[g*LANE_W +: LANE_W])
    );
    assign dst[g*LANE_W +: LANE_W] = (view == VIEW_LIVE) ?
      src[g*LANE_W +: LANE_W] : held[g*LANE_W +: LANE_W];
  end

  assign drive = drive_on(rst_n, oe_n);

endmodule

// File: rtl/ubt_core.sv
module ubt_core #(
  parameter int WIDTH = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk
);

  // Internal events brought out for the checker
  logic [WIDTH-1:0] ab_held_w;
  logic [WIDTH-1:0] ba_held_w;
  logic             ab_rise_w;
  logic             ba_rise_w;

  ubt_direction #(.WIDTH(WIDTH), .LANES(LANES)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (a_in),
    .oe_n    (ab_oe_n),
    .le      (ab_le),
    .cap_clk (ab_clk),
    .dst     (b_out),
    .drive   (b_drive),
    .held    (ab_held_w),
    .rise    (ab_rise_w)
  );

  ubt_direction #(.WIDTH(WIDTH), .LANES(LANES)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (b_in),
    .oe_n    (ba_oe_n),
    .le      (ba_le),
    .cap_clk (ba_clk),
    .dst     (a_out),
    .drive   (a_drive),
    .held    (ba_held_w),
    .rise    (ba_rise_w)
  );

endmodule

// File: rtl/ubt_checks.sv
module ubt_checks #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             a_drive,
  input logic             b_drive,
  input logic             ab_oe_n,
  input logic             ab_le,
  input logic             ba_oe_n,
  input logic             ba_le,
  input logic [WIDTH-1:0] ab_held,
  input logic [WIDTH-1:0] ba_held,
  input logic             ab_rise,
  input logic             ba_rise
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_transparent_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> b_out == a_in);
  assert_transparent_ba_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> a_out == b_in);

  assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_rise) |=> $stable(ab_held));

  assert_capture_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_rise) |=> ab_held == $past(a_in));

  assert_no_glitch_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(ab_le)) |-> ab_held == $past(a_in));

  assert_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> !b_drive);
  assert_drive_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_oe_n |-> b_drive);

  assert_hold_ba_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_rise) |=> $stable(ba_held));
  assert_capture_ba_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && ba_rise) |=> ba_held == $past(b_in));

  assert_no_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && !ba_oe_n) |-> (a_drive && b_drive));

  // R8: reset clears storage and releases both buses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R8: assert (ab_held == '0 && ba_held == '0 &&
                                     !a_drive && !b_drive);
    end
  end

endmodule

bind ubt_core ubt_checks #(.WIDTH(WIDTH)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_out   (a_out),
  .b_out   (b_out),
  .a_drive (a_drive),
  .b_drive (b_drive),
  .ab_oe_n (ab_oe_n),
  .ab_le   (ab_le),
  .ba_oe_n (ba_oe_n),
  .ba_le   (ba_le),
  .ab_held (ab_held_w),
  .ba_held (ba_held_w),
  .ab_rise (ab_rise_w),
  .ba_rise (ba_rise_w)
);

// File: tb/sim_ubt_core.sv
`timescale 1ns/1ps
module sim_ubt_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] a_in = '0, b_in = '0;
  logic [17:0] a_out, b_out;
  logic        a_drive, b_drive;
  logic        ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b1;
  logic        ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ubt_core u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk)
  );

  // {le, clk, a_in, expected b_out}; sampled 1 ns after the next clk edge
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b0, 18'h3A5A5, 18'h00000},
    {1'b0, 1'b1, 18'h3A5A5, 18'h3A5A5},
    {1'b0, 1'b1, 18'h01234, 18'h3A5A5},
    {1'b0, 1'b0, 18'h01234, 18'h3A5A5},
    {1'b1, 1'b0, 18'h0F0F0, 18'h0F0F0},
    {1'b1, 1'b1, 18'h2AAAA, 18'h2AAAA},
    {1'b0, 1'b1, 18'h15555, 18'h2AAAA},
    {1'b0, 1'b0, 18'h15555, 18'h2AAAA},
    {1'b0, 1'b1, 18'h15555, 18'h15555},
    {1'b0, 1'b1, 18'h3FFFF, 18'h15555},
    {1'b0, 1'b0, 18'h00000, 18'h15555},
    {1'b0, 1'b1, 18'h1FF00, 18'h1FF00},
    {1'b1, 1'b1, 18'h00001, 18'h00001},
    {1'b0, 1'b0, 18'h3FFFF, 18'h00001}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    a_in = 18'h2BEEF;
    repeat (3) step();
    chk("R8 drive off in reset", {16'b0, a_drive, b_drive}, 18'h0);
    chk("R8 stored word zero in reset", b_out, 18'h0);
    @(negedge clk) rst_n = 1'b1;
    step(); step();
    chk("R8 clock held high through reset captures nothing", b_out, 18'h0);
    @(negedge clk) ab_oe_n = 1'b0;
    #1 chk("R5 b_drive on", {17'b0, b_drive}, 18'h1);

    // R1/R2/R3/R4 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ab_le = VEC[i][37]; ab_clk = VEC[i][36]; a_in = VEC[i][35:18];
      step();
      chk($sformatf("R1/R2/R3/R4 vector %0d", i), b_out, VEC[i][17:0]);
      chk("R5 drive during vectors", {17'b0, b_drive}, 18'h1);
    end

    @(negedge clk) ab_oe_n = 1'b1;
    #1 chk("R5 b_drive off", {17'b0, b_drive}, 18'h0);
    @(negedge clk) ab_oe_n = 1'b0;

    // R4: new data arrives together with the fall of ab_le
    @(negedge clk) begin ab_le = 1'b1; a_in = 18'h0ABCD; end
    step();
    chk("R1 transparent", b_out, 18'h0ABCD);
    @(negedge clk) begin ab_le = 1'b0; a_in = 18'h31111; end
    step();
    chk("R4 held word is pre-fall sample", b_out, 18'h0ABCD);

    // R6: B-to-A path
    @(negedge clk) begin ba_oe_n = 1'b0; b_in = 18'h1C3C3; end
    step();
    @(negedge clk) ba_clk = 1'b1;
    step();
    chk("R6 capture on ba_clk rise", a_out, 18'h1C3C3);
    @(negedge clk) begin ba_le = 1'b1; b_in = 18'h00777; end
    #1 chk("R6 transparent", a_out, 18'h00777);
    step();
    @(negedge clk) begin ba_le = 1'b0; b_in = 18'h00000; end
    step();
    chk("R6 hold after fall", a_out, 18'h00777);

    // R7: independence of the two stored words
    @(negedge clk) begin ba_clk = 1'b0; b_in = 18'h12345; end
    step();
    @(negedge clk) ba_clk = 1'b1;
    step();
    chk("R7 B-to-A capture", a_out, 18'h12345);
    chk("R7 A-to-B word untouched", b_out, 18'h0ABCD);
    @(negedge clk) begin ab_clk = 1'b1; a_in = 18'h3C003; end
    step();
    chk("R7 A-to-B capture", b_out, 18'h3C003);
    chk("R7 B-to-A word untouched", a_out, 18'h12345);

    // R9: both enables active
    chk("R9 both drivers on", {16'b0, a_drive, b_drive}, 18'h3);
    if (a_drive && b_drive) $display("note R9: bus contention flagged, both directions driving");

    // R10: lanes carry their own data
    @(negedge clk) begin ab_clk = 1'b0; a_in = 18'h1FE01; end
    step();
    @(negedge clk) ab_clk = 1'b1;
    step();
    @(negedge clk) a_in = 18'h0;
    step();
    chk("R10 upper lane", {9'b0, b_out[17:9]}, 18'h000FF);
    chk("R10 lower lane", {9'b0, b_out[8:0]}, 18'h00001);

    summary();
  end

endmodule